// File: doc/BRIEF.md
# Two-Step Converter Bus Controller

This block is the digital side of an 8-bit two-step (half-flash) converter. A 9-bit sample word stands in for the analog input. Values from 0 to 255 are in range, and any value above 255 is over full scale. The block turns a chip select, a write strobe and a read strobe, all active low, into a conversion, a latched result and a completion interrupt. It supports two strobe protocols, chosen by a mode input.

With mode high, the block runs write-then-read. A write strobe starts the conversion. The result is latched a fixed number of cycles after the write strobe rises, unless a read strobe arrives earlier and cuts the wait short. With mode low, the block runs read-only. The read strobe both starts the conversion and later reads the result. A ready output pulls low while the controller is busy. High impedance is modelled by enable outputs: `data_oe` enables the data bus and `rdy_pull` means the ready line is driven low. The overflow flag is always driven.

The result is formed in two steps. A 4-bit coarse code comes from the upper range. A 4-bit fine code then comes from the residue that is left after subtracting the coarse level.

All strobes and the mode input pass through two synchroniser flops. Edge-triggered actions take effect on the third rising clock edge after an input changes. Level-based bus enabling takes effect on the second.

Top module: `hfadc_ctrl`

## Requirements
- R1: Mode high selects write-then-read. Mode low selects read-only, which is also the state after reset. A mode input left at 0 therefore behaves as read-only.
- R2: While chip select is high, a strobe has no effect. No conversion starts, the interrupt stays high, the data output keeps its value, and neither `data_oe` nor `rdy_pull` is asserted.
- R3: In write-then-read mode, a write falling edge with chip select low starts a conversion. If no early read occurs, the result is latched, `int_n` goes low and `ofl_n` is updated on the edge TIMEOUT_CYC+3 after the write strobe rises.
- R4: In write-then-read mode, a read falling edge after the write rise and before the timeout latches the result instead. `int_n` then goes low on the third edge after the read strobe falls.
- R5: Once `int_n` is low, a rising edge of the read strobe or of chip select sets it high on the third edge after that rise. A latch in the same cycle wins over the clear.
- R6: In write-then-read mode, `data_oe` is high exactly when the synchronised chip select and read strobe are both low. This is visible on the second edge after the inputs change.
- R7: In read-only mode, a read falling edge with chip select low starts a conversion. The result is latched and `int_n` goes low on the edge CONV_CYC+3 after that fall. `data_oe` rises on that same edge while chip select and the read strobe stay low, and never before.
- R8: In read-only mode, `rdy_pull` rises on the third edge after chip select falls. It drops on the edge where the result is latched, or on a chip select rise. In write-then-read mode it is never asserted.
- R9: At a latch, `ofl_n` goes low if the sample exceeds 255, and `data_out` becomes 8'hFF. Otherwise `ofl_n` is high. `ofl_n` is always driven and changes only at a latch.
- R10: For an in-range sample, `data_out` equals the sample. The code is built as the coarse 4-bit code in bits 7:4 and the fine 4-bit residue code in bits 3:0.
- R11: After reset, `data_out` is 0, `data_oe` and `rdy_pull` are 0, and `int_n` and `ofl_n` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 1 | 1 = write-then-read, 0 = read-only |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| sample | input | 9 | Digital stand-in for the analog level; above 255 is over range |
| data_out | output | 8 | Output latch contents |
| data_oe | output | 1 | Data bus enable (low = high impedance) |
| rdy_pull | output | 1 | 1 = ready line pulled low, 0 = released |
| int_n | output | 1 | Completion interrupt, active low |
| ofl_n | output | 1 | Overflow flag, active low, always driven |

## Verification
Inputs are driven on falling clock edges and outputs are sampled 1 ns after a rising edge. Every timed result therefore lands on a known edge count. The counts are:
- bus enable: 2 edges after a chip select or read change;
- interrupt clear and ready pull: 3 edges after the causing strobe;
- early-read latch: 3 edges after the read strobe falls;
- timeout latch: TIMEOUT_CYC+3 edges after the write strobe rises;
- read-only latch: CONV_CYC+3 edges after the read strobe falls.

For each timed result, the bench checks the output one edge before it is due, to see that it has not changed yet. It then checks again on the due edge, so a result that comes early or late by a cycle is caught.

// File: rtl/hfadc_pkg.sv
// Package: shared sizes and sequencer states for the two-step converter
// controller. Assumes an even result width so it splits into two halves.
package hfadc_pkg;
    localparam int RES_BITS = 8;
    localparam int HALF     = RES_BITS / 2;
    localparam int LEVELS   = (1 << HALF) - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WR_LOW = 2'd1,
        ST_WAIT   = 2'd2,
        ST_RO_RUN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/hfadc_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous control inputs.
// Assumes each bit is an independent level; RST_VAL gives the idle levels.
module hfadc_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flop stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d_in;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hfadc_twostep.sv
// Module: combinational two-step quantiser. It forms a coarse code from
// the clamped level, then a fine code from the residue that remains.
// Assumes the top bit of the level flags anything above full scale.
module hfadc_twostep
    import hfadc_pkg::*;
#(
    parameter int RB  = RES_BITS,
    parameter int HB  = RB / 2,
    parameter int NLV = (1 << HB) - 1
) (
    input  logic [RB:0]   level,
    output logic [RB-1:0] code,
    output logic          over
);
    logic [RB-1:0]  clamp;
    logic [NLV-1:0] coarse_th;
    logic [NLV-1:0] fine_th;
    logic [HB-1:0]  coarse;
    logic [HB-1:0]  fine;
    logic [RB-1:0]  residue;

    assign over  = level[RB];
    assign clamp = over ? '1 : level[RB-1:0];

    // One comparator per coarse step and per fine step.
    for (genvar k = 1; k <= NLV; k++) begin : g_cmp
        assign coarse_th[k-1] = (clamp >= RB'(k << HB));
        assign fine_th[k-1]   = (residue >= RB'(k));
    end

    // Thermometer to binary for the coarse stage.
    always_comb begin
        coarse = '0;
        for (int i = 0; i < NLV; i++) coarse = coarse + HB'(coarse_th[i]);
    end

    // Residue left after removing the coarse level.
    assign residue = clamp - {coarse, {HB{1'b0}}};

    // Thermometer to binary for the fine stage.
    always_comb begin
        fine = '0;
        for (int i = 0; i < NLV; i++) fine = fine + HB'(fine_th[i]);
    end

    assign code = {coarse, fine};
endmodule

// File: rtl/hfadc_seq.sv
// Module: conversion sequencer. It starts conversions on strobe edges,
// counts the timeout or conversion time, latches the result, and drives
// the interrupt, ready and bus enables. Assumes synchronised inputs.
module hfadc_seq
    import hfadc_pkg::*;
#(
    parameter int RB          = RES_BITS,
    parameter int TIMEOUT_CYC = 160,
    parameter int CONV_CYC    = 300,
    parameter int CNT_W       = $clog2((TIMEOUT_CYC > CONV_CYC ? TIMEOUT_CYC : CONV_CYC) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_s,
    input  logic          cs_s,
    input  logic          wr_s,
    input  logic          rd_s,
    input  logic [RB:0]   sample,
    input  logic [RB-1:0] conv_code,
    input  logic          conv_over,
    output logic [RB:0]   smp_q,
    output logic [RB-1:0] data_out,
    output logic          data_oe,
    output logic          rdy_pull,
    output logic          int_n,
    output logic          ofl_n
);
    localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CV_LAST = CNT_W'(CONV_CYC - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             cs_p, wr_p, rd_p, valid;
    logic             cs_fall, cs_rise, wr_fall, wr_rise, rd_fall, rd_rise;
    logic             start_wr, start_ro, wr_up, early, expire, do_latch;

    // Previous-cycle copies of the strobes for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p <= 1'b1;
            wr_p <= 1'b1;
            rd_p <= 1'b1;
        end else begin
            cs_p <= cs_s;
            wr_p <= wr_s;
            rd_p <= rd_s;
        end
    end

    assign cs_fall = cs_p & ~cs_s;
    assign cs_rise = ~cs_p & cs_s;
    assign wr_fall = wr_p & ~wr_s;
    assign wr_rise = ~wr_p & wr_s;
    assign rd_fall = rd_p & ~rd_s;
    assign rd_rise = ~rd_p & rd_s;

    // Decode the start, early-read and timeout events.
    always_comb begin
        start_wr = (state == ST_IDLE) & mode_s & ~cs_s & wr_fall;
        start_ro = (state == ST_IDLE) & ~mode_s & ~cs_s & rd_fall;
        wr_up    = (state == ST_WR_LOW) & wr_rise;
        early    = (state == ST_WAIT) & ~cs_s & rd_fall;
        expire   = ((state == ST_WAIT) & (cnt == TO_LAST)) |
                   ((state == ST_RO_RUN) & (cnt == CV_LAST));
        do_latch = early | expire;
    end

    // State, counter and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            smp_q <= '0;
        end else if (start_wr) begin
            state <= ST_WR_LOW;
            smp_q <= sample;
        end else if (start_ro) begin
            state <= ST_RO_RUN;
            cnt   <= '0;
            smp_q <= sample;
        end else if (wr_up) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else if (do_latch) begin
            state <= ST_IDLE;
        end else if (state == ST_WAIT || state == ST_RO_RUN) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Output latch, overflow flag and result-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            ofl_n    <= 1'b1;
            valid    <= 1'b0;
        end else if (do_latch) begin
            data_out <= conv_code;
            ofl_n    <= ~conv_over;
            valid    <= 1'b1;
        end else if (start_wr || start_ro) begin
            valid <= 1'b0;
        end
    end

    // Interrupt: a latch sets it low, and a read or select rise clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  int_n <= 1'b1;
        else if (do_latch)           int_n <= 1'b0;
        else if (rd_rise || cs_rise) int_n <= 1'b1;
    end

    // Ready pull-down: read-only mode only, released at latch or deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rdy_pull <= 1'b0;
        else if (do_latch || cs_rise) rdy_pull <= 1'b0;
        else if (cs_fall && !mode_s)  rdy_pull <= 1'b1;
    end

    // Bus enable: level-based in write-then-read, after completion in read-only.
    assign data_oe = ~cs_s & ~rd_s & (mode_s | (valid & ~rd_fall));
endmodule

// File: rtl/hfadc_ctrl.sv
// Module: top of the two-step converter bus controller. It synchronises
// the bus inputs, quantises the captured sample and sequences conversions.
// Assumes the sample word stays stable while a conversion is started.
module hfadc_ctrl
    import hfadc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 160,
    parameter int CONV_CYC    = 300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode,
    input  logic                cs_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic [RES_BITS:0]   sample,
    output logic [RES_BITS-1:0] data_out,
    output logic                data_oe,
    output logic                rdy_pull,
    output logic                int_n,
    output logic                ofl_n
);
    logic [3:0]            sync_q;
    logic [RES_BITS:0]     smp_q;
    logic [RES_BITS-1:0]   conv_code;
    logic                  conv_over;

    // Bit order is {mode, cs, wr, rd}. Mode idles low; the strobes idle high.
    hfadc_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({mode, cs_n, wr_n, rd_n}),
        .q     (sync_q)
    );

    hfadc_twostep #(.RB(RES_BITS), .HB(HALF), .NLV(LEVELS)) u_quant (
        .level (smp_q),
        .code  (conv_code),
        .over  (conv_over)
    );

    hfadc_seq #(
        .RB          (RES_BITS),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .CONV_CYC    (CONV_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (sync_q[3]),
        .cs_s      (sync_q[2]),
        .wr_s      (sync_q[1]),
        .rd_s      (sync_q[0]),
        .sample    (sample),
        .conv_code (conv_code),
        .conv_over (conv_over),
        .smp_q     (smp_q),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .rdy_pull  (rdy_pull),
        .int_n     (int_n),
        .ofl_n     (ofl_n)
    );
endmodule

// File: rtl/hfadc_chk.sv
// Module: property checker for hfadc_ctrl, attached by bind. It observes
// only the top-level ports and relates them across the synchroniser delay.
module hfadc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic [7:0] data_out,
    input logic       data_oe,
    input logic       rdy_pull,
    input logic       int_n,
    input logic       ofl_n
);
    // R2
    deselect_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n, 2) |-> !data_oe);

    // R5
    int_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> (($past(rd_n, 3) && !$past(rd_n, 4)) ||
                          ($past(cs_n, 3) && !$past(cs_n, 4))));

    // R8
    ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> !rdy_pull);

    // R9
    ovf_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ofl_n) |-> !int_n);

    // R3
    data_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> !int_n);
endmodule

bind hfadc_ctrl hfadc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .data_out (data_out),
    .data_oe  (data_oe),
    .rdy_pull (rdy_pull),
    .int_n    (int_n),
    .ofl_n    (ofl_n)
);

// File: tb/hfadc_ctrl_test.sv
`timescale 1ns/1ps
// Bench: directed and seeded random conversions in both modes, checked
// against edge counts and expected codes computed here.
module hfadc_ctrl_test;
    localparam int TO = 160;
    localparam int CV = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [8:0] sample = '0;
    logic [7:0] data_out;
    logic       data_oe, rdy_pull, int_n, ofl_n;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    hfadc_ctrl #(.TIMEOUT_CYC(TO), .CONV_CYC(CV)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .sample(sample), .data_out(data_out), .data_oe(data_oe),
        .rdy_pull(rdy_pull), .int_n(int_n), .ofl_n(ofl_n)
    );

    function automatic logic [7:0] exp_code(input logic [8:0] s);
        return (s > 9'd255) ? 8'hFF : s[7:0];
    endfunction

    function automatic logic exp_ofl_n(input logic [8:0] s);
        return (s <= 9'd255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk) mode = m;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_int(input bit by_cs);
        @(negedge clk);
        if (by_cs) cs_n = 1'b1; else rd_n = 1'b1;
        edges(2);
        check("R5 int before clear edge", int_n, 0);
        edges(1);
        check("R5 int cleared", int_n, 1);
        @(negedge clk) begin cs_n = 1'b1; rd_n = 1'b1; end
        repeat (4) @(negedge clk);
    endtask

    // Write-then-read conversion; early read after k cycles when early is set.
    task automatic wr_conv(input logic [8:0] s, input bit early, input int k, input bit by_cs);
        @(negedge clk) begin sample = s; cs_n = 1'b0; end
        repeat (2) @(negedge clk) wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        if (early) begin
            repeat (k) @(negedge clk);
            rd_n = 1'b0;
            edges(2);
            check("R6 oe on read", data_oe, 1);
            check("R4 int not yet low", int_n, 1);
            edges(1);
            check("R4 early latch int", int_n, 0);
        end else begin
            edges(TO + 2);
            check("R3 int before timeout", int_n, 1);
            edges(1);
            check("R3 timeout latch int", int_n, 0);
            @(negedge clk) rd_n = 1'b0;
            edges(1);
            check("R6 oe not yet", data_oe, 0);
            edges(1);
            check("R6 oe on read", data_oe, 1);
        end
        check("R10 code", data_out, exp_code(s));
        check("R9 overflow flag", ofl_n, exp_ofl_n(s));
        check("R8 no ready pull in R1 write mode", rdy_pull, 0);
        clear_int(by_cs);
    endtask

    // Read-only conversion: rd falls k cycles after chip select falls.
    task automatic ro_conv(input logic [8:0] s, input int k, input bit by_cs);
        @(negedge clk) begin sample = s; cs_n = 1'b0; end
        edges(2);
        check("R8 ready not yet", rdy_pull, 0);
        edges(1);
        check("R8 ready pulled", rdy_pull, 1);
        repeat (k) @(negedge clk);
        rd_n = 1'b0;
        edges(CV + 2);
        check("R7 int before done", int_n, 1);
        check("R7 oe before done", data_oe, 0);
        check("R8 ready held", rdy_pull, 1);
        edges(1);
        check("R7 done int", int_n, 0);
        check("R7 oe at done", data_oe, 1);
        check("R8 ready released", rdy_pull, 0);
        check("R10 code", data_out, exp_code(s));
        check("R9 overflow flag", ofl_n, exp_ofl_n(s));
        clear_int(by_cs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        edges(1);
        // R11 reset state
        check("R11 data", data_out, 0);
        check("R11 oe", data_oe, 0);
        check("R11 ready", rdy_pull, 0);
        check("R11 int", int_n, 1);
        check("R11 ofl", ofl_n, 1);

        // R1 write-then-read: timeout path, then early read
        set_mode(1'b1);
        wr_conv(9'h0A7, 1'b0, 0, 1'b0);
        wr_conv(9'h13C, 1'b1, 1, 1'b1);
        wr_conv(9'h0FF, 1'b1, TO - 1, 1'b0);
        wr_conv(9'h000, 1'b0, 0, 1'b1);

        // R2 strobes with chip select high in write mode
        held = data_out;
        @(negedge clk) sample = 9'h055;
        @(negedge clk) wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        rd_n = 1'b0;
        edges(TO + 10);
        check("R2 int idle", int_n, 1);
        check("R2 data kept", data_out, held);
        check("R2 no oe", data_oe, 0);
        @(negedge clk) rd_n = 1'b1;

        // R1 read-only mode, then R2 read with chip select high
        set_mode(1'b0);
        ro_conv(9'h05A, 1, 1'b0);
        ro_conv(9'h1FF, 3, 1'b1);
        held = data_out;
        @(negedge clk) rd_n = 1'b0;
        edges(CV + 10);
        check("R2 ro int idle", int_n, 1);
        check("R2 ro no ready", rdy_pull, 0);
        check("R2 ro data kept", data_out, held);
        @(negedge clk) rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // Seeded random mix of modes, samples, paths and clear sources
        for (int i = 0; i < 14; i++) begin
            logic [8:0] s;
            bit         m, e, c;
            int         k;
            s = 9'($urandom % 512);
            m = 1'($urandom % 2);
            e = 1'($urandom % 2);
            c = 1'($urandom % 2);
            k = 1 + int'($urandom % (TO - 1));
            set_mode(m);
            if (m) wr_conv(s, e, k, c);
            else   ro_conv(s, 1 + (k % 5), c);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule